// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block routes a set of external interrupt request lines to processors. Each line owns a two-word redirection entry. The entry holds a mask, a trigger mode (edge or level), an input polarity, a destination mode (physical or logical), an 8-bit vector and an 8-bit destination processor identifier. A line that is active and unmasked becomes pending. The lowest-numbered pending line is turned into a delivery message that carries the entry's vector, destination and destination mode. The message is held on a valid/ready output until the receiver accepts it.

Software reaches every register through a two-slot window. A write to byte offset 0x00 selects a register index. A read or write at byte offset 0x10 then acts on the selected register. Index 0x00 is a fixed identification register. Index 0x01 is a version register that reports the highest entry number. The table starts at index 0x10, and line i uses index 0x10+2i for its control word and 0x10+2i+1 for its destination word.

A level-triggered line that has been accepted is blocked until an end-of-interrupt notice arrives. The notice carries the serviced vector and unblocks every level line programmed with that vector.

Top module: `irq_router`

## Requirements
- R1: After reset no message is offered (`msg_valid` low), and every entry's control word reads 0x0001_0000: the mask (bit 16) is set and the other fields are zero.
- R2: A write to byte offset 0x00 keeps only `bus_wdata[7:0]` as the index, and a read of offset 0x00 returns that index in bits 7:0 with the other bits zero.
- R3: Index 0x00 reads `CTRL_ID` in bits 31:24. Index 0x01 reads NUM_LINES-1 in bits 23:16 and `VERSION` in bits 7:0. Every other bit of both registers reads zero.
- R4: The control word at index 0x10+2i stores bit 16 (mask), bit 15 (level mode), bit 13 (active low), bit 11 (logical destination) and bits 7:0 (vector). The destination word at index 0x11+2i stores bits 31:24 (destination ID). All other bits read zero.
- R5: A data access to an index that is neither 0x00, 0x01 nor a table word reads zero, and a write to it changes no register.
- R6: A masked line produces no message. An edge that arrives while the line is masked is dropped.
- R7: An edge-mode line delivers exactly one message per rising edge of its conditioned input. Keeping the input active does not redeliver. An accepted message is not offered in the cycle after acceptance.
- R8: The conditioned input is the pin XOR the active-low bit, so an active-low line triggers on a falling edge of its pin.
- R9: A level-mode line is offered while its conditioned input is active and it is not blocked. Acceptance blocks it. An end-of-interrupt with the line's vector unblocks it, and an end-of-interrupt with any other vector does not.
- R10: When several lines are pending, the lowest-numbered line is offered first.
- R11: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_vector`, `msg_dest` and `msg_logical` stay unchanged.
- R12: A message carries the vector, the destination ID and the logical-mode bit from the entry of the line it serves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on `bus_rdata` one cycle later |
| bus_addr | input | 8 | Byte offset: 0x00 index slot, 0x10 data slot |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_in | input | NUM_LINES | External interrupt request pins |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | 8 | Vector being retired |
| msg_valid | output | 1 | Delivery message offered |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Vector of the offered message |
| msg_dest | output | 8 | Destination processor ID |
| msg_logical | output | 1 | Destination is logical (1) or physical (0) |

## Verification
The bench builds the block with NUM_LINES = 6, CTRL_ID = 0x0E and VERSION = 0x20. With six lines the first index past the table is 0x1C, so the top table boundary can be probed next to the gap at 0x02..0x0F. The version read reports 5, which could not be mistaken for a count. Six lines are enough to hold the edge, level, active-low, masked and two-line priority cases at the same time. Random control and destination words then exercise every writable bit against bench-computed masks.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam logic [7:0] OFS_INDEX = 8'h00;
    localparam logic [7:0] OFS_DATA  = 8'h10;

    localparam logic [7:0] IDX_ID    = 8'h00;
    localparam logic [7:0] IDX_VER   = 8'h01;
    localparam logic [7:0] IDX_TABLE = 8'h10;

    typedef struct packed {
        logic       mask;
        logic       level;
        logic       act_low;
        logic       logical;
        logic [7:0] vector;
        logic [7:0] dest;
    } route_t;

    localparam route_t ROUTE_RESET = '{
        mask: 1'b1, level: 1'b0, act_low: 1'b0, logical: 1'b0,
        vector: 8'h00, dest: 8'h00
    };

    function automatic logic [31:0] ctrl_word(route_t r);
        logic [31:0] w;
        w      = '0;
        w[16]  = r.mask;
        w[15]  = r.level;
        w[13]  = r.act_low;
        w[11]  = r.logical;
        w[7:0] = r.vector;
        return w;
    endfunction

    function automatic logic [31:0] dest_word(route_t r);
        return {r.dest, 24'h000000};
    endfunction

    function automatic route_t load_ctrl(route_t r, logic [31:0] w);
        route_t n;
        n         = r;
        n.mask    = w[16];
        n.level   = w[15];
        n.act_low = w[13];
        n.logical = w[11];
        n.vector  = w[7:0];
        return n;
    endfunction

    function automatic route_t load_dest(route_t r, logic [31:0] w);
        route_t n;
        n      = r;
        n.dest = w[31:24];
        return n;
    endfunction

endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import irq_router_pkg::*;
#(
    parameter int         NUM_LINES = 24,
    parameter logic [7:0] CTRL_ID   = 8'h01,
    parameter logic [7:0] VERSION   = 8'h11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [7:0]                    bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    output route_t [NUM_LINES-1:0]        routes,
    output logic [7:0]                    index
);

    localparam int         TABLE_WORDS = 2 * NUM_LINES;
    localparam logic [7:0] TOP_ENTRY   = 8'(NUM_LINES - 1);

    typedef struct packed {
        logic [7:0]             index;
        logic [31:0]            rdata;
        route_t [NUM_LINES-1:0] routes;
    } regs_t;

    regs_t       s_d, s_q;
    logic [7:0]  rel_idx;
    logic        in_table;
    logic [31:0] sel_value;

    assign rel_idx  = s_q.index - IDX_TABLE;
    assign in_table = (s_q.index >= IDX_TABLE) && ({24'h0, rel_idx} < 32'(TABLE_WORDS));

    always_comb begin
        sel_value = '0;
        if (s_q.index == IDX_ID) begin
            sel_value = {CTRL_ID, 24'h000000};
        end else if (s_q.index == IDX_VER) begin
            sel_value = {8'h00, TOP_ENTRY, 8'h00, VERSION};
        end else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (in_table && rel_idx[7:1] == 7'(i)) begin
                    sel_value = rel_idx[0] ? dest_word(s_q.routes[i])
                                           : ctrl_word(s_q.routes[i]);
                end
            end
        end
    end

    always_comb begin
        s_d = s_q;
        if (bus_wr && bus_addr == OFS_INDEX) begin
            s_d.index = bus_wdata[7:0];
        end
        if (bus_wr && bus_addr == OFS_DATA) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (in_table && rel_idx[7:1] == 7'(i)) begin
                    s_d.routes[i] = rel_idx[0] ? load_dest(s_q.routes[i], bus_wdata)
                                               : load_ctrl(s_q.routes[i], bus_wdata);
                end
            end
        end
        if (bus_rd) begin
            if (bus_addr == OFS_INDEX)     s_d.rdata = {24'h0, s_q.index};
            else if (bus_addr == OFS_DATA) s_d.rdata = sel_value;
            else                           s_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.index <= '0;
            s_q.rdata <= '0;
            for (int i = 0; i < NUM_LINES; i++) begin
                s_q.routes[i] <= ROUTE_RESET;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;
    assign routes    = s_q.routes;
    assign index     = s_q.index;

endmodule

// File: rtl/irq_cond.sv
module irq_cond
    import irq_router_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int SEL_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   irq_in,
    input  route_t [NUM_LINES-1:0] routes,
    input  logic                   take,
    input  logic [SEL_W-1:0]       take_idx,
    input  logic                   eoi_valid,
    input  logic [7:0]             eoi_vector,
    output logic [NUM_LINES-1:0]   req
);

    typedef struct packed {
        logic [NUM_LINES-1:0] prev;
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] busy;
    } cond_t;

    cond_t                s_d, s_q;
    logic [NUM_LINES-1:0] active;
    logic [NUM_LINES-1:0] taken;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign active[g] = irq_in[g] ^ routes[g].act_low;
        assign taken[g]  = take && (take_idx == SEL_W'(g));
        assign req[g]    = !routes[g].mask &&
                           (routes[g].level ? (active[g] && !s_q.busy[g]) : s_q.pend[g]);
    end

    always_comb begin
        s_d      = s_q;
        s_d.prev = active;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (taken[i]) begin
                if (routes[i].level) s_d.busy[i] = 1'b1;
                else                 s_d.pend[i] = 1'b0;
            end
            if (!routes[i].mask && !routes[i].level && active[i] && !s_q.prev[i]) begin
                s_d.pend[i] = 1'b1;
            end
            if (eoi_valid && routes[i].level && routes[i].vector == eoi_vector && !taken[i]) begin
                s_d.busy[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_router_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int SEL_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   req,
    input  route_t [NUM_LINES-1:0] routes,
    input  logic                   msg_ready,
    output logic                   msg_valid,
    output logic [7:0]             msg_vector,
    output logic [7:0]             msg_dest,
    output logic                   msg_logical,
    output logic                   take,
    output logic [SEL_W-1:0]       sel
);

    typedef struct packed {
        logic             valid;
        logic [7:0]       vector;
        logic [7:0]       dest;
        logic             logical;
        logic [SEL_W-1:0] sel;
    } arb_t;

    arb_t             s_d, s_q;
    logic             found;
    logic [SEL_W-1:0] pick;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                pick  = SEL_W'(i);
            end
        end
    end

    assign take = s_q.valid && msg_ready;

    always_comb begin
        s_d = s_q;
        if (take) begin
            s_d.valid = 1'b0;
        end else if (!s_q.valid && found) begin
            s_d.valid   = 1'b1;
            s_d.sel     = pick;
            s_d.vector  = routes[pick].vector;
            s_d.dest    = routes[pick].dest;
            s_d.logical = routes[pick].logical;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign msg_valid   = s_q.valid;
    assign msg_vector  = s_q.vector;
    assign msg_dest    = s_q.dest;
    assign msg_logical = s_q.logical;
    assign sel         = s_q.sel;

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int         NUM_LINES = 24,
    parameter logic [7:0] CTRL_ID   = 8'h01,
    parameter logic [7:0] VERSION   = 8'h11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 eoi_valid,
    input  logic [7:0]           eoi_vector,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [7:0]           msg_vector,
    output logic [7:0]           msg_dest,
    output logic                 msg_logical
);

    localparam int SEL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    route_t [NUM_LINES-1:0] routes_w;
    logic [NUM_LINES-1:0]   req_w;
    logic [7:0]             index_w;
    logic                   take_w;
    logic [SEL_W-1:0]       sel_w;

    irq_regs #(
        .NUM_LINES (NUM_LINES),
        .CTRL_ID   (CTRL_ID),
        .VERSION   (VERSION)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .routes    (routes_w),
        .index     (index_w)
    );

    irq_cond #(
        .NUM_LINES (NUM_LINES),
        .SEL_W     (SEL_W)
    ) u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .routes     (routes_w),
        .take       (take_w),
        .take_idx   (sel_w),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .req        (req_w)
    );

    irq_arb #(
        .NUM_LINES (NUM_LINES),
        .SEL_W     (SEL_W)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req_w),
        .routes      (routes_w),
        .msg_ready   (msg_ready),
        .msg_valid   (msg_valid),
        .msg_vector  (msg_vector),
        .msg_dest    (msg_dest),
        .msg_logical (msg_logical),
        .take        (take_w),
        .sel         (sel_w)
    );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NUM_LINES = 24,
    parameter int SEL_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [7:0]           bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [7:0]           index_q,
    input logic [NUM_LINES-1:0] req_vec,
    input logic [SEL_W-1:0]     sel_idx,
    input logic                 msg_valid,
    input logic                 msg_ready,
    input logic [7:0]           msg_vector,
    input logic [7:0]           msg_dest,
    input logic                 msg_logical
);

    logic [NUM_LINES-1:0] req_prev;
    logic [NUM_LINES-1:0] below_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_prev <= '0;
        else        req_prev <= req_vec;
    end

    assign below_sel = (NUM_LINES'(1) << sel_idx) - NUM_LINES'(1);

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !msg_valid); // R1

    AST_INDEX_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h00) |=> (index_q == $past(bus_wdata[7:0]))); // R2

    AST_OFFER_FROM_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> req_prev[sel_idx]); // R6

    AST_NO_REOFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid); // R7

    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> ((req_prev & below_sel) == '0)); // R10

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) &&
                                       $stable(msg_dest) && $stable(msg_logical))); // R11

endmodule

bind irq_router irq_router_chk #(
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .index_q     (index_w),
    .req_vec     (req_w),
    .sel_idx     (sel_w),
    .msg_valid   (msg_valid),
    .msg_ready   (msg_ready),
    .msg_vector  (msg_vector),
    .msg_dest    (msg_dest),
    .msg_logical (msg_logical)
);

// File: tb/sim_irq_router.sv
module sim_irq_router;

    localparam int         N   = 6;
    localparam logic [7:0] CID = 8'h0E;
    localparam logic [7:0] VER = 8'h20;
    localparam logic [31:0] CTRL_BITS = 32'h0001_A8FF;
    localparam logic [31:0] DEST_BITS = 32'hFF00_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq_in = '0;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;
    logic          msg_valid, msg_ready = 1'b0;
    logic [7:0]    msg_vector, msg_dest;
    logic          msg_logical;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    irq_router #(.NUM_LINES(N), .CTRL_ID(CID), .VERSION(VER)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_dest(msg_dest), .msg_logical(msg_logical)
    );

    function automatic logic [31:0] exp_ctrl(logic [31:0] v);
        return v & CTRL_BITS;
    endfunction

    function automatic logic [31:0] exp_dest(logic [31:0] v);
        return v & DEST_BITS;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, req, act, exp);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
        bus_write(8'h00, {24'h0, idx});
        bus_write(8'h10, d);
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
        bus_write(8'h00, {24'h0, idx});
        bus_read(8'h10, d);
    endtask

    task automatic program_line(input int line, input logic [31:0] ctrl, input logic [31:0] dst);
        reg_write(8'(8'h11 + 2 * line), dst);
        reg_write(8'(8'h10 + 2 * line), ctrl);
    endtask

    task automatic wait_msg(input int lim, output bit got);
        got = 1'b0;
        for (int k = 0; k < lim && !got; k++) begin
            @(negedge clk);
            if (msg_valid) got = 1'b1;
        end
    endtask

    task automatic accept_msg();
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic pulse_eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] shadow_c [N];
        logic [31:0] shadow_d [N];
        bit          got;

        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_eq("R1 idle after reset", {31'h0, msg_valid}, 32'h0);
        for (int i = 0; i < N; i++) begin
            reg_read(8'(8'h10 + 2 * i), rd);
            check_eq("R1 reset control word", rd, 32'h0001_0000);
            shadow_c[i] = 32'h0001_0000;
            shadow_d[i] = 32'h0;
        end

        // R2: index keeps only low byte
        bus_write(8'h00, 32'hDEAD_01A5);
        bus_read(8'h00, rd);
        check_eq("R2 index low byte", rd, 32'h0000_00A5);

        // R3: identification and version
        reg_read(8'h00, rd);
        check_eq("R3 id register", rd, {CID, 24'h0});
        reg_read(8'h01, rd);
        check_eq("R3 version register", rd, {8'h0, 8'(N - 1), 8'h0, VER});

        // R4: directed all-ones write
        reg_write(8'h10, 32'hFFFF_FFFF);
        reg_read(8'h10, rd);
        check_eq("R4 control all ones", rd, 32'h0001_A8FF);
        reg_write(8'h11, 32'hFFFF_FFFF);
        reg_read(8'h11, rd);
        check_eq("R4 destination all ones", rd, 32'hFF00_0000);
        shadow_c[0] = 32'h0001_A8FF;
        shadow_d[0] = 32'hFF00_0000;

        // R4: random words, mask kept set so nothing is delivered
        for (int it = 0; it < 24; it++) begin
            int          ln;
            bit          hi;
            logic [31:0] v;
            ln = int'($urandom % N);
            hi = 1'($urandom);
            v  = $urandom;
            if (hi) begin
                reg_write(8'(8'h11 + 2 * ln), v);
                shadow_d[ln] = exp_dest(v);
                reg_read(8'(8'h11 + 2 * ln), rd);
                check_eq("R4 random destination word", rd, shadow_d[ln]);
            end else begin
                v = v | 32'h0001_0000;
                reg_write(8'(8'h10 + 2 * ln), v);
                shadow_c[ln] = exp_ctrl(v);
                reg_read(8'(8'h10 + 2 * ln), rd);
                check_eq("R4 random control word", rd, shadow_c[ln]);
            end
        end
        for (int i = 0; i < N; i++) begin
            reg_read(8'(8'h10 + 2 * i), rd);
            check_eq("R4 control retained", rd, shadow_c[i]);
        end

        // R5: unimplemented indices
        reg_write(8'h05, 32'hFFFF_FFFF);
        reg_read(8'h05, rd);
        check_eq("R5 gap index reads zero", rd, 32'h0);
        reg_write(8'h1C, 32'hFFFF_FFFF);
        reg_read(8'h1C, rd);
        check_eq("R5 past-table index reads zero", rd, 32'h0);
        reg_read(8'h1B, rd);
        check_eq("R5 last entry untouched", rd, shadow_d[N-1]);
        reg_read(8'h1A, rd);
        check_eq("R5 last control untouched", rd, shadow_c[N-1]);
        check_eq("R5 no message", {31'h0, msg_valid}, 32'h0);

        // Put every line into a known masked state
        for (int i = 0; i < N; i++) program_line(i, 32'h0001_0000, 32'h0);

        // R6: masked line
        program_line(2, 32'h0001_0022, 32'h0900_0000);
        irq_in[2] = 1'b1;
        repeat (3) @(negedge clk);
        irq_in[2] = 1'b0;
        wait_msg(10, got);
        check_eq("R6 masked line silent", {31'h0, got}, 32'h0);

        // R7 R11 R12: edge line
        program_line(1, 32'h0000_0031, 32'h0700_0000);
        irq_in[1] = 1'b1;
        wait_msg(10, got);
        check_eq("R7 edge delivers", {31'h0, got}, 32'h1);
        check_eq("R12 vector", {24'h0, msg_vector}, 32'h31);
        check_eq("R12 destination", {24'h0, msg_dest}, 32'h07);
        check_eq("R12 physical mode", {31'h0, msg_logical}, 32'h0);
        repeat (4) @(negedge clk);
        check_eq("R11 held valid", {31'h0, msg_valid}, 32'h1);
        check_eq("R11 held vector", {24'h0, msg_vector}, 32'h31);
        accept_msg();
        check_eq("R7 dropped after accept", {31'h0, msg_valid}, 32'h0);
        wait_msg(10, got);
        check_eq("R7 no redelivery while high", {31'h0, got}, 32'h0);
        irq_in[1] = 1'b0;
        repeat (2) @(negedge clk);
        irq_in[1] = 1'b1;
        wait_msg(10, got);
        check_eq("R7 second edge delivers", {31'h0, got}, 32'h1);
        accept_msg();
        irq_in[1] = 1'b0;

        // R8: active-low edge line
        irq_in[3] = 1'b1;
        repeat (2) @(negedge clk);
        program_line(3, 32'h0000_2043, 32'h0300_0000);
        wait_msg(6, got);
        check_eq("R8 idle high pin silent", {31'h0, got}, 32'h0);
        irq_in[3] = 1'b0;
        wait_msg(10, got);
        check_eq("R8 falling edge delivers", {31'h0, got}, 32'h1);
        check_eq("R8 vector", {24'h0, msg_vector}, 32'h43);
        accept_msg();
        irq_in[3] = 1'b1;
        wait_msg(6, got);
        check_eq("R8 rising pin silent", {31'h0, got}, 32'h0);

        // R9 R12: level line, logical mode
        program_line(4, 32'h0000_8855, 32'h0200_0000);
        irq_in[4] = 1'b1;
        wait_msg(10, got);
        check_eq("R9 level delivers", {31'h0, got}, 32'h1);
        check_eq("R12 logical mode", {31'h0, msg_logical}, 32'h1);
        check_eq("R12 level destination", {24'h0, msg_dest}, 32'h02);
        accept_msg();
        wait_msg(10, got);
        check_eq("R9 blocked until eoi", {31'h0, got}, 32'h0);
        pulse_eoi(8'h99);
        wait_msg(10, got);
        check_eq("R9 other vector eoi no effect", {31'h0, got}, 32'h0);
        pulse_eoi(8'h55);
        wait_msg(10, got);
        check_eq("R9 matching eoi redelivers", {31'h0, got}, 32'h1);
        check_eq("R9 vector", {24'h0, msg_vector}, 32'h55);
        accept_msg();
        irq_in[4] = 1'b0;
        pulse_eoi(8'h55);
        wait_msg(10, got);
        check_eq("R9 inactive level silent", {31'h0, got}, 32'h0);

        // R10: simultaneous requests
        program_line(0, 32'h0000_0010, 32'h0100_0000);
        program_line(5, 32'h0000_0060, 32'h0500_0000);
        @(negedge clk);
        irq_in[0] = 1'b1;
        irq_in[5] = 1'b1;
        wait_msg(10, got);
        check_eq("R10 lowest first", {24'h0, msg_vector}, 32'h10);
        accept_msg();
        wait_msg(10, got);
        check_eq("R10 next line offered", {31'h0, got}, 32'h1);
        check_eq("R10 second vector", {24'h0, msg_vector}, 32'h60);
        check_eq("R12 second destination", {24'h0, msg_dest}, 32'h05);
        accept_msg();
        wait_msg(10, got);
        check_eq("R10 nothing left", {31'h0, got}, 32'h0);
        irq_in = '0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule